// File: doc/BRIEF.md
# Serial DAC Word Deserializer with Justification Modes

This block is the serial front end of a double-buffered 14-bit converter interface. An external host sends words over a serial clock and a serial data line, framed by an active-low frame strobe. A fast system clock samples all of these lines through synchronizers and finds their edges. The block shifts in a 16-bit frame and keeps 14 of those bits. Two static mode pins choose which 14 bits are kept: one sets the bit order (most significant first or least significant first), and the other sets whether the two pad bits lead or trail the frame. The 14 data bits are written into an input holding register.

A second register drives the converter. It takes the input register's value when an active-low load strobe falls while no frame is in progress. If the load strobe is low when a frame completes, the new word goes straight through at frame completion. This gives an auto-update behaviour when the strobe is held low permanently.

A frame that is cut short by the frame strobe rising early is discarded.

Top module: `sdac_deser`

## Requirements
- R1: After reset, `in_word_o` and `dac_word_o` are zero and `dac_upd_o` is low.
- R2: A falling edge of `frame_n_i` starts a frame. The data bit is taken on each of the next 16 falling edges of `ser_clk_i` that occur while `frame_n_i` is low. The new word appears on `in_word_o` three system clocks after the sixteenth serial falling edge reaches the pins.
- R3: With `fmt_msb_i`=0 and `pad_last_i`=0, frame bits 1 and 2 are ignored. Bit 3 is data bit 0 and bit 16 is data bit 13 (bits are numbered 1 to 16 in order of arrival).
- R4: With `fmt_msb_i`=0 and `pad_last_i`=1, bit 1 is data bit 0 and bit 14 is data bit 13. Bits 15 and 16 are ignored.
- R5: With `fmt_msb_i`=1 and `pad_last_i`=0, bits 1 and 2 are ignored. Bit 3 is data bit 13 and bit 16 is data bit 0.
- R6: With `fmt_msb_i`=1 and `pad_last_i`=1, bit 1 is data bit 13 and bit 14 is data bit 0. Bits 15 and 16 are ignored.
- R7: A falling edge of `load_n_i` outside a frame copies `in_word_o` into `dac_word_o`. `dac_upd_o` pulses high for one cycle as `dac_word_o` changes, and `dac_word_o` changes at no other time.
- R8: A falling edge of `load_n_i` during a frame causes no update. If `load_n_i` is still low when the sixteenth bit lands, `dac_word_o` takes the new word one cycle after `in_word_o` does.
- R9: If `load_n_i` is high when the sixteenth bit lands, the frame does not update `dac_word_o`.
- R10: With `load_n_i` held low, every completed frame updates `dac_word_o`.
- R11: If `frame_n_i` rises before 16 bits arrive, the partial frame is dropped and `in_word_o` keeps its value. The next frame starts counting from bit 1.
- R12: Serial clock edges are ignored while `frame_n_i` is high, and also after the sixteenth bit until a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; data taken on its falling edges |
| ser_dat_i | input | 1 | Serial data |
| frame_n_i | input | 1 | Active-low frame strobe |
| load_n_i | input | 1 | Active-low converter-register load strobe |
| fmt_msb_i | input | 1 | Bit order: 1 = most significant bit first |
| pad_last_i | input | 1 | Pad position: 1 = pad bits trail the data |
| in_word_o | output | 14 | Input holding register |
| dac_word_o | output | 14 | Converter register |
| dac_upd_o | output | 1 | One-cycle pulse when the converter register is written |

## Verification
The assertions assume four things about the inputs:
- the serial clock is slow enough that each of its levels lasts several system clocks;
- the data line is stable around each serial falling edge;
- the mode pins change only between frames;
- a load-strobe edge never lands in the same system clock as a frame-strobe edge.

The stimulus follows these rules:
- each serial clock level is held for four system clocks;
- data changes only with the rising serial edge;
- mode pins change only while the frame strobe is high;
- load-strobe changes are placed on bit boundaries, well away from frame-strobe edges.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // index of each synchronized line inside the sync vector
  localparam int SIG_SCLK  = 0;
  localparam int SIG_DAT   = 1;
  localparam int SIG_FRAME = 2;
  localparam int SIG_LOAD  = 3;
  localparam int SIG_COUNT = 4;
  // idle levels: clock high, data low, strobes high
  localparam logic [SIG_COUNT-1:0] SIG_IDLE = 4'b1101;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {(STAGES+1){RST_VAL[g]}};
      else     chain_q <= {chain_q[STAGES-1:0], d_i[g]};
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign fall_o[g] = chain_q[STAGES] & ~chain_q[STAGES-1];
    assign rise_o[g] = ~chain_q[STAGES] & chain_q[STAGES-1];
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_fall_i,
  input  logic              frm_rise_i,
  input  logic              frm_lvl_i,
  input  logic              sclk_fall_i,
  input  logic              dat_i,
  input  logic              fmt_msb_i,
  input  logic              pad_last_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic               active_q, done_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q, sr_nxt;
  logic [DATA_W-1:0]  word_q, window, word_nxt;
  logic               take, last;

  assign take   = active_q & sclk_fall_i & ~frm_lvl_i;
  assign last   = (cnt_q == CNT_W'(FRAME_W - 1));
  // earliest bit ends up in the top position
  assign sr_nxt = {sr_q[FRAME_W-2:0], dat_i};
  assign window = pad_last_i ? sr_nxt[FRAME_W-1 -: DATA_W] : sr_nxt[DATA_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign word_nxt[i] = fmt_msb_i ? window[i] : window[DATA_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      word_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (frm_fall_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (frm_rise_i) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (take) begin
        sr_q <= sr_nxt;
        if (last) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          word_q   <= word_nxt;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign word_o   = word_q;

  // R2: bit counter never passes the frame length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(FRAME_W));
  // R11: holding register moves only with a completed frame
  p_word_only_on_done_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> done_q);
  // R12: no count is held while no frame is open
  p_idle_clear_r12: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> cnt_q == '0);
endmodule

// File: rtl/sdac_xfer.sv
module sdac_xfer #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_fall_i,
  input  logic              ld_lvl_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              upd_o
);
  logic [DATA_W-1:0] dac_q;
  logic              upd_q, auto_ld, manual_ld;

  assign auto_ld   = done_i & ~ld_lvl_i;
  assign manual_ld = ld_fall_i & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= auto_ld | manual_ld;
      if (auto_ld | manual_ld) dac_q <= word_i;
    end
  end

  assign dac_o = dac_q;
  assign upd_o = upd_q;

  // R7: converter register changes only with the update pulse
  p_dac_only_on_upd_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_q) |-> upd_q);
  // R8: an update never stems from a strobe edge inside a frame
  p_no_upd_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> ($past(done_i) || !$past(busy_i)));
  // R9: strobe high at frame end gives no update
  p_no_auto_high_r9: assert property (@(posedge clk) disable iff (rst)
    (done_i && ld_lvl_i) |=> !upd_q);
  // R10: strobe low at frame end forwards the new word
  p_auto_low_r10: assert property (@(posedge clk) disable iff (rst)
    (done_i && !ld_lvl_i) |=> (upd_q && dac_q == $past(word_i)));
endmodule

// File: rtl/sdac_deser.sv
module sdac_deser #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              frame_n_i,
  input  logic              load_n_i,
  input  logic              fmt_msb_i,
  input  logic              pad_last_i,
  output logic [DATA_W-1:0] in_word_o,
  output logic [DATA_W-1:0] dac_word_o,
  output logic              dac_upd_o
);
  import sdac_pkg::*;

  logic [SIG_COUNT-1:0] raw, lvl, fall, rise;
  logic                 active, done;
  logic                 unused_edges;

  assign raw[SIG_SCLK]  = ser_clk_i;
  assign raw[SIG_DAT]   = ser_dat_i;
  assign raw[SIG_FRAME] = frame_n_i;
  assign raw[SIG_LOAD]  = load_n_i;

  sdac_sync #(.N(SIG_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(SIG_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw),
    .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );

  assign unused_edges = ^{rise[SIG_SCLK], rise[SIG_DAT], rise[SIG_LOAD],
                          fall[SIG_DAT], lvl[SIG_SCLK]};

  sdac_shift #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst),
    .frm_fall_i(fall[SIG_FRAME]), .frm_rise_i(rise[SIG_FRAME]),
    .frm_lvl_i(lvl[SIG_FRAME]), .sclk_fall_i(fall[SIG_SCLK]),
    .dat_i(lvl[SIG_DAT]), .fmt_msb_i(fmt_msb_i), .pad_last_i(pad_last_i),
    .active_o(active), .done_o(done), .word_o(in_word_o)
  );

  sdac_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst(rst),
    .ld_fall_i(fall[SIG_LOAD]), .ld_lvl_i(lvl[SIG_LOAD]),
    .busy_i(active), .done_i(done), .word_i(in_word_o),
    .dac_o(dac_word_o), .upd_o(dac_upd_o)
  );
endmodule

// File: tb/sim_sdac_deser.sv
module sim_sdac_deser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, sdat = 1'b0, frm = 1'b1, ld = 1'b1, fmt = 1'b0, just = 1'b0;
  logic [13:0] in_w, dac_w;
  logic upd;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdac_deser u0 (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .frame_n_i(frm), .load_n_i(ld), .fmt_msb_i(fmt), .pad_last_i(just),
    .in_word_o(in_w), .dac_word_o(dac_w), .dac_upd_o(upd)
  );

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed { logic sc, dt, fr, ld; } raw_t;
  raw_t q[$];
  raw_t a, b;
  bit   m_active, m_done, m_upd, ndone;
  int   m_cnt;
  bit   m_bits[$];
  logic [13:0] m_in, m_dac;

  function automatic logic [13:0] extract(input bit bits[$], input bit f, input bit j);
    logic [13:0] w = '0;
    for (int p = 0; p < 16; p++) begin
      int idx = j ? p : p - 2;
      if (idx >= 0 && idx < 14) w[f ? 13 - idx : idx] = bits[p];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q = {};
      for (int i = 0; i < 4; i++) q.push_front('{1'b1, 1'b0, 1'b1, 1'b1});
      m_active = 0; m_done = 0; m_upd = 0; m_cnt = 0;
      m_bits = {}; m_in = '0; m_dac = '0;
    end else begin
      q.push_front('{sclk, sdat, frm, ld});
      a = q[2]; b = q[3];
      void'(q.pop_back());
      // load register step (uses previous state)
      m_upd = 0;
      if ((m_done && !a.ld) || (b.ld && !a.ld && !m_active)) begin
        m_dac = m_in; m_upd = 1;
      end
      // frame step
      ndone = 0;
      if (b.fr && !a.fr) begin
        m_active = 1; m_cnt = 0; m_bits = {};
      end else if (!b.fr && a.fr) begin
        m_active = 0; m_cnt = 0; m_bits = {};
      end else if (m_active && b.sc && !a.sc && !a.fr) begin
        m_bits.push_back(a.dt);
        m_cnt++;
        if (m_cnt == 16) begin
          m_in = extract(m_bits, fmt, just);
          ndone = 1; m_active = 0; m_cnt = 0; m_bits = {};
        end
      end
      m_done = ndone;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 in_word per-cycle", in_w, m_in);
      chk("R7 dac_word per-cycle", dac_w, m_dac);
      chk("R7 upd per-cycle", {13'b0, upd}, {13'b0, m_upd});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit stream_bit(input logic [13:0] v, input int p);
    int idx = just ? p : p - 2;
    if (idx < 0 || idx > 13) return p[0];
    return fmt ? v[13 - idx] : v[idx];
  endfunction

  task automatic bitcyc(input bit bv);
    sclk = 1'b1; sdat = bv; tick(4);
    sclk = 1'b0; tick(4);
  endtask

  task automatic send(input logic [13:0] v, input int nbits, input int fall_at,
                      input int rise_at, input int extra);
    sclk = 1'b1; tick(4);
    frm = 1'b0; tick(4);
    for (int p = 0; p < nbits; p++) begin
      if (p == fall_at) ld = 1'b0;
      if (p == rise_at) ld = 1'b1;
      bitcyc(stream_bit(v, p));
    end
    for (int e = 0; e < extra; e++) bitcyc(1'b1);
    sclk = 1'b1; tick(4);
    frm = 1'b1; tick(8);
  endtask

  task automatic pulse_load();
    ld = 1'b0; tick(8);
    ld = 1'b1; tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    chk("R1 reset in_word", in_w, 14'h0);
    chk("R1 reset dac_word", dac_w, 14'h0);
    chk("R1 reset upd", {13'b0, upd}, 14'h0);

    // R3: LSB first, pads lead
    fmt = 0; just = 0; tick(4);
    send(14'h2A5C, 16, -1, -1, 0);
    chk("R3 mode lsb/pad-first word", in_w, 14'h2A5C);
    chk("R9 no update with load high", dac_w, 14'h0);
    pulse_load();
    chk("R7 load edge outside frame", dac_w, 14'h2A5C);

    // R4 + R8: LSB first, pads trail; load falls mid-frame and stays low
    fmt = 0; just = 1; tick(4);
    send(14'h1234, 16, 5, -1, 0);
    chk("R4 mode lsb/pad-last word", in_w, 14'h1234);
    chk("R8 update at sixteenth edge", dac_w, 14'h1234);
    ld = 1'b1; tick(8);

    // R5 + R9: MSB first, pads lead; load low then high mid-frame
    fmt = 1; just = 0; tick(4);
    send(14'h3F01, 16, 3, 10, 0);
    chk("R5 mode msb/pad-first word", in_w, 14'h3F01);
    chk("R9 load released mid-frame", dac_w, 14'h1234);

    // R6 + R12: MSB first, pads trail; extra edges after bit 16
    fmt = 1; just = 1; tick(4);
    send(14'h0ABC, 16, -1, -1, 3);
    chk("R6 mode msb/pad-last word", in_w, 14'h0ABC);
    chk("R12 edges after sixteenth ignored", in_w, 14'h0ABC);

    // R12: edges with frame high
    for (int k = 0; k < 6; k++) bitcyc(k[0]);
    tick(8);
    chk("R12 edges outside frame ignored", in_w, 14'h0ABC);

    // R10: load held low
    ld = 1'b0; tick(8);
    send(14'h1111, 16, -1, -1, 0);
    chk("R10 auto update frame 1", dac_w, 14'h1111);
    send(14'h2222, 16, -1, -1, 0);
    chk("R10 auto update frame 2", dac_w, 14'h2222);
    ld = 1'b1; tick(8);

    // R11: aborted frame then a full one
    fmt = 0; just = 0; tick(4);
    send(14'h3FFF, 9, -1, -1, 0);
    chk("R11 partial frame dropped", in_w, 14'h2222);
    send(14'h3333, 16, -1, -1, 0);
    chk("R11 count restarts", in_w, 14'h3333);
    chk("R2 full frame after abort", in_w, 14'h3333);
    tick(8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule